// File: doc/BRIEF.md
# Single-Cycle Integer Core (Twelve-Instruction Subset)

This block is a 32-bit processor that finishes one instruction per accepted fetch. It puts the current program counter on `instr_addr`. The surrounding system answers on `instr_data` and raises `instr_valid` in the same cycle. The core then decodes the word, reads its operands, computes a result and writes the register file or the data memory. All of this happens within that single cycle. The program counter also moves to its successor in that cycle.

The datapath contains a 32 × 32-bit register file, a five-operation ALU, a sign-extender, branch and jump target adders, and a 256-word data memory. Programs cannot build an arbitrary constant address. For that reason the stack pointer (register 29) leaves reset already holding a usable data address, given by a parameter.

The fetch side is a valid/ready pair. The core raises `fetch_ready` from the first clock edge after reset is released. An instruction is consumed on a rising edge only when `instr_valid` and `fetch_ready` are both high. While `instr_valid` is low, the core waits with `instr_addr` held steady, and nothing inside it changes. Every register-file write is also shown on a debug port in the cycle it commits.

Top module: `scp_core`

## Requirements
- R1: While `rst_n` is low, `instr_addr` reads 0x00400000 and `fetch_ready` is low. After reset, register 29 holds `SP_INIT` (default 0x00000200) and every other register holds 0. `fetch_ready` rises at the first rising edge after release.
- R2: A rising edge with `instr_valid` low leaves `instr_addr` unchanged, and `dbg_wr_en` stays low in that cycle.
- R3: Register-format words have opcode bits[31:26]=0, rs=[25:21], rt=[20:16], rd=[15:11], shamt=[10:6]=0 and funct=[5:0]. Funct 0x20, 0x22, 0x24 and 0x25 write rs+rt, rs−rt, rs&rt and rs|rt into rd, and then the PC advances by 4.
- R4: Funct 0x2A writes 1 into rd when rs is less than rt as signed two's-complement numbers, and writes 0 otherwise.
- R5: Opcode 0x08 writes rs plus the sign-extended imm[15:0] into rt.
- R6: Register 0 reads as zero, and any write aimed at register 0 is discarded (`dbg_wr_en` stays low).
- R7: Opcode 0x2B stores rt, and opcode 0x23 loads into rt. Both use the data word at index bits[9:2] of rs + sign-extended imm, so address bits above 9 are ignored. A store writes no register.
- R8: Opcode 0x04 compares rs and rt. If they are equal, the next PC is PC+4 + (sign-extended imm << 2); otherwise it is PC+4.
- R9: Opcode 0x02 jumps to {PC+4[31:28], imm26, 2'b00}. Opcode 0x03 does the same and also writes PC+4 into register 31.
- R10: Funct 0x08 with opcode 0 loads the PC from rs and writes no register.
- R11: Any other opcode, any other funct, or a register-format word with nonzero shamt acts as a no-op: the PC advances by 4 and no register or memory changes. The all-zero word is therefore a no-op.
- R12: `dbg_wr_en` is high exactly in a cycle whose instruction commits a register write. During that cycle `dbg_wr_idx` and `dbg_wr_data` carry the destination index and the value written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_addr | output | 32 | Byte address of the instruction wanted this cycle (the PC) |
| instr_data | input | 32 | Instruction word for `instr_addr` |
| instr_valid | input | 1 | `instr_data` is valid and may be consumed |
| fetch_ready | output | 1 | Core accepts an instruction this cycle |
| dbg_wr_en | output | 1 | A register write commits at the next rising edge |
| dbg_wr_idx | output | 5 | Destination register of that write |
| dbg_wr_data | output | 32 | Value being written |

## Verification
Some properties are checked on every clock: the PC holds still across any edge without a handshake; every sequential instruction moves the PC by exactly four; debug writes appear only inside an accepted cycle; no write reaches register 0; stores never raise a register write; and jal links register 31 to PC+4. Other behaviour can only be shown by bench scenarios that run a program through the core. These cover the arithmetic results, signed comparison, the branch and jump targets, and data surviving a store-then-load round trip. They also cover aliasing of high address bits onto the same word, the effect of reset on the stack pointer, and operand values visible through later instructions.

// File: rtl/scp_pkg.sv
package scp_pkg;

  localparam int XLEN = 32;

  // primary opcodes, bits [31:26]
  localparam logic [5:0] OP_REG  = 6'h00;
  localparam logic [5:0] OP_J    = 6'h02;
  localparam logic [5:0] OP_JAL  = 6'h03;
  localparam logic [5:0] OP_BEQ  = 6'h04;
  localparam logic [5:0] OP_ADDI = 6'h08;
  localparam logic [5:0] OP_LW   = 6'h23;
  localparam logic [5:0] OP_SW   = 6'h2B;

  // function codes of register-format words, bits [5:0]
  localparam logic [5:0] FN_JR  = 6'h08;
  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;

  typedef enum logic [2:0] {ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_SLT} alu_op_e;
  typedef enum logic [1:0] {DST_RD, DST_RT, DST_LINK} dst_sel_e;
  typedef enum logic [1:0] {WB_ALU, WB_MEM, WB_LINK} wb_sel_e;
  typedef enum logic [1:0] {NPC_SEQ, NPC_BEQ, NPC_JUMP, NPC_REG} npc_sel_e;

  typedef struct packed {
    logic     reg_we;
    dst_sel_e dst;
    wb_sel_e  wb;
    logic     use_imm;
    alu_op_e  op;
    logic     mem_we;
    npc_sel_e npc;
  } ctrl_t;

endpackage

// File: rtl/scp_decode.sv
module scp_decode
  import scp_pkg::*;
(
  input  logic [5:0] opc,
  input  logic [5:0] fn,
  input  logic [4:0] shamt,
  output ctrl_t      ctrl
);

  always_comb begin
    // default: no-op that falls through to PC+4 (R11)
    ctrl = '{reg_we: 1'b0, dst: DST_RD, wb: WB_ALU, use_imm: 1'b0,
             op: ALU_ADD, mem_we: 1'b0, npc: NPC_SEQ};
    case (opc)
      OP_REG: begin
        if (shamt == 5'd0) begin
          case (fn)
            FN_ADD: begin ctrl.reg_we = 1'b1; ctrl.op = ALU_ADD; end
            FN_SUB: begin ctrl.reg_we = 1'b1; ctrl.op = ALU_SUB; end
            FN_AND: begin ctrl.reg_we = 1'b1; ctrl.op = ALU_AND; end
            FN_OR:  begin ctrl.reg_we = 1'b1; ctrl.op = ALU_OR;  end
            FN_SLT: begin ctrl.reg_we = 1'b1; ctrl.op = ALU_SLT; end
            FN_JR:  ctrl.npc = NPC_REG;
            default: ;
          endcase
        end
      end
      OP_ADDI: begin
        ctrl.reg_we  = 1'b1;
        ctrl.dst     = DST_RT;
        ctrl.use_imm = 1'b1;
      end
      OP_LW: begin
        ctrl.reg_we  = 1'b1;
        ctrl.dst     = DST_RT;
        ctrl.use_imm = 1'b1;
        ctrl.wb      = WB_MEM;
      end
      OP_SW: begin
        ctrl.use_imm = 1'b1;
        ctrl.mem_we  = 1'b1;
      end
      OP_BEQ: ctrl.npc = NPC_BEQ;
      OP_J:   ctrl.npc = NPC_JUMP;
      OP_JAL: begin
        ctrl.npc    = NPC_JUMP;
        ctrl.reg_we = 1'b1;
        ctrl.dst    = DST_LINK;
        ctrl.wb     = WB_LINK;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/scp_alu.sv
module scp_alu
  import scp_pkg::*;
#(
  parameter int W = XLEN
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_op_e      op,
  output logic [W-1:0] res
);

  always_comb begin
    case (op)
      ALU_ADD: res = a + b;
      ALU_SUB: res = a - b;
      ALU_AND: res = a & b;
      ALU_OR:  res = a | b;
      ALU_SLT: res = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
      default: res = '0;
    endcase
  end

endmodule

// File: rtl/scp_regfile.sv
module scp_regfile #(
  parameter int          NREG    = 32,
  parameter int          W       = 32,
  parameter int          SP_IDX  = 29,
  parameter logic [31:0] SP_INIT = 32'h0000_0200,
  localparam int         AW      = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] ra_idx,
  output logic [W-1:0]  ra_data,
  input  logic [AW-1:0] rb_idx,
  output logic [W-1:0]  rb_data,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_idx,
  input  logic [W-1:0]  wr_data
);

  logic [W-1:0] regs [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    if (g == 0) begin : g_zero
      assign regs[g] = '0;
    end else begin : g_store
      localparam logic [W-1:0] RST_VAL = (g == SP_IDX) ? W'(SP_INIT) : '0;
      logic [W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                               q <= RST_VAL;
        else if (wr_en && (wr_idx == AW'(g)))     q <= wr_data;
      end
      assign regs[g] = q;
    end
  end

  assign ra_data = regs[ra_idx];
  assign rb_data = regs[rb_idx];

  // the core must never route a write to the hard-wired zero entry
  p_no_zero_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_idx != '0));

endmodule

// File: rtl/scp_dmem.sv
module scp_dmem #(
  parameter int  DEPTH = 256,
  parameter int  W     = 32,
  localparam int IW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic [IW-1:0] idx,
  input  logic          wr_en,
  input  logic [W-1:0]  wr_data,
  output logic [W-1:0]  rd_data
);

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[idx] <= wr_data;
  end

  assign rd_data = mem[idx];

endmodule

// File: rtl/scp_core.sv
module scp_core
  import scp_pkg::*;
#(
  parameter int          NREG       = 32,
  parameter int          DMEM_DEPTH = 256,
  parameter logic [31:0] PC_RESET   = 32'h0040_0000,
  parameter int          SP_IDX     = 29,
  parameter logic [31:0] SP_INIT    = 32'h0000_0200,
  parameter int          LINK_IDX   = 31,
  localparam int         RAW        = $clog2(NREG),
  localparam int         MIW        = $clog2(DMEM_DEPTH)
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [31:0]     instr_addr,
  input  logic [31:0]     instr_data,
  input  logic            instr_valid,
  output logic            fetch_ready,
  output logic            dbg_wr_en,
  output logic [RAW-1:0]  dbg_wr_idx,
  output logic [XLEN-1:0] dbg_wr_data
);

  logic [31:0]     pc_q, pc_next, pc_plus4, br_target, jmp_target;
  logic            ready_q, commit;
  logic [RAW-1:0]  rs_idx, rt_idx, rd_idx, dst_idx;
  logic [XLEN-1:0] rs_val, rt_val, imm_sext, alu_b, alu_res, mem_rdata, wb_data;
  logic            rf_we;
  ctrl_t           ctrl;

  // ---------------- fetch handshake and PC ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ready_q <= 1'b0;
    else        ready_q <= 1'b1;
  end

  assign commit      = instr_valid && ready_q;
  assign fetch_ready = ready_q;
  assign instr_addr  = pc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pc_q <= PC_RESET;
    else if (commit) pc_q <= pc_next;
  end

  // ---------------- field extraction ----------------
  assign rs_idx   = instr_data[21 +: RAW];
  assign rt_idx   = instr_data[16 +: RAW];
  assign rd_idx   = instr_data[11 +: RAW];
  assign imm_sext = {{(XLEN-16){instr_data[15]}}, instr_data[15:0]};

  scp_decode u_dec (
    .opc   (instr_data[31:26]),
    .fn    (instr_data[5:0]),
    .shamt (instr_data[10:6]),
    .ctrl  (ctrl)
  );

  // ---------------- operands and execute ----------------
  scp_regfile #(
    .NREG    (NREG),
    .W       (XLEN),
    .SP_IDX  (SP_IDX),
    .SP_INIT (SP_INIT)
  ) u_rf (
    .clk     (clk),
    .rst_n   (rst_n),
    .ra_idx  (rs_idx),
    .ra_data (rs_val),
    .rb_idx  (rt_idx),
    .rb_data (rt_val),
    .wr_en   (rf_we),
    .wr_idx  (dst_idx),
    .wr_data (wb_data)
  );

  assign alu_b = ctrl.use_imm ? imm_sext : rt_val;

  scp_alu #(.W(XLEN)) u_alu (
    .a   (rs_val),
    .b   (alu_b),
    .op  (ctrl.op),
    .res (alu_res)
  );

  scp_dmem #(.DEPTH(DMEM_DEPTH), .W(XLEN)) u_dmem (
    .clk     (clk),
    .idx     (alu_res[2 +: MIW]),
    .wr_en   (commit && ctrl.mem_we),
    .wr_data (rt_val),
    .rd_data (mem_rdata)
  );

  // ---------------- next PC ----------------
  assign pc_plus4   = pc_q + 32'd4;
  assign br_target  = pc_plus4 + {imm_sext[29:0], 2'b00};
  assign jmp_target = {pc_plus4[31:28], instr_data[25:0], 2'b00};

  always_comb begin
    case (ctrl.npc)
      NPC_BEQ:  pc_next = (rs_val == rt_val) ? br_target : pc_plus4;
      NPC_JUMP: pc_next = jmp_target;
      NPC_REG:  pc_next = rs_val;
      default:  pc_next = pc_plus4;
    endcase
  end

  // ---------------- write-back ----------------
  always_comb begin
    case (ctrl.dst)
      DST_RT:   dst_idx = rt_idx;
      DST_LINK: dst_idx = RAW'(LINK_IDX);
      default:  dst_idx = rd_idx;
    endcase
  end

  always_comb begin
    case (ctrl.wb)
      WB_MEM:  wb_data = mem_rdata;
      WB_LINK: wb_data = pc_plus4;
      default: wb_data = alu_res;
    endcase
  end

  assign rf_we       = commit && ctrl.reg_we && (dst_idx != '0);
  assign dbg_wr_en   = rf_we;
  assign dbg_wr_idx  = dst_idx;
  assign dbg_wr_data = wb_data;

  // ---------------- assertions ----------------
  p_pc_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(pc_q));

  p_seq_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && ctrl.npc == NPC_SEQ) |=> (pc_q == $past(pc_q) + 32'd4));

  p_dbg_in_commit_r12: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_wr_en |-> (instr_valid && fetch_ready));

  p_store_no_reg_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && ctrl.mem_we) |-> !dbg_wr_en);

  p_link_value_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && ctrl.npc == NPC_JUMP && ctrl.reg_we)
      |-> (dbg_wr_idx == RAW'(LINK_IDX) && dbg_wr_data == instr_addr + 32'd4));

endmodule

// File: tb/scp_core_tb.sv
`timescale 1ns/1ps
module scp_core_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] instr_addr, instr_data = 32'h0;
  logic        instr_valid = 1'b0;
  logic        fetch_ready, dbg_wr_en;
  logic [4:0]  dbg_wr_idx;
  logic [31:0] dbg_wr_data;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  scp_core u_dut (
    .clk (clk), .rst_n (rst_n),
    .instr_addr (instr_addr), .instr_data (instr_data), .instr_valid (instr_valid),
    .fetch_ready (fetch_ready),
    .dbg_wr_en (dbg_wr_en), .dbg_wr_idx (dbg_wr_idx), .dbg_wr_data (dbg_wr_data)
  );

  typedef struct packed {
    logic [31:0] ins;
    logic [31:0] pc;
    logic        we;
    logic [4:0]  wa;
    logic [31:0] wd;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 27;
  localparam vec_t VEC [NV] = '{
    '{32'h20100005, 32'h00400000, 1'b1, 5'd16, 32'h00000005, 4'd5},  // R5 addi r16,r0,5
    '{32'h2011FFFD, 32'h00400004, 1'b1, 5'd17, 32'hFFFFFFFD, 4'd5},  // R5 addi r17,r0,-3
    '{32'h02119020, 32'h00400008, 1'b1, 5'd18, 32'h00000002, 4'd3},  // R3 add
    '{32'h02119822, 32'h0040000C, 1'b1, 5'd19, 32'h00000008, 4'd3},  // R3 sub
    '{32'h0211A024, 32'h00400010, 1'b1, 5'd20, 32'h00000005, 4'd3},  // R3 and
    '{32'h0211A825, 32'h00400014, 1'b1, 5'd21, 32'hFFFFFFFD, 4'd3},  // R3 or
    '{32'h0230B02A, 32'h00400018, 1'b1, 5'd22, 32'h00000001, 4'd4},  // R4 -3 < 5
    '{32'h0211B82A, 32'h0040001C, 1'b1, 5'd23, 32'h00000000, 4'd4},  // R4 5 < -3 false
    '{32'hAFB00004, 32'h00400020, 1'b0, 5'd0,  32'h00000000, 4'd7},  // R7 sw r16,4(r29)
    '{32'h8FA80004, 32'h00400024, 1'b1, 5'd8,  32'h00000005, 4'd7},  // R7 lw r8,4(r29)
    '{32'h03A04820, 32'h00400028, 1'b1, 5'd9,  32'h00000200, 4'd1},  // R1 stack pointer value
    '{32'h00000000, 32'h0040002C, 1'b0, 5'd0,  32'h00000000, 4'd11}, // R11 all-zero nop
    '{32'h02100020, 32'h00400030, 1'b0, 5'd0,  32'h00000000, 4'd6},  // R6 write to r0 dropped
    '{32'h00005020, 32'h00400034, 1'b1, 5'd10, 32'h00000000, 4'd6},  // R6 r0 reads zero
    '{32'h3C010001, 32'h00400038, 1'b0, 5'd0,  32'h00000000, 4'd11}, // R11 unknown opcode
    '{32'h12110003, 32'h0040003C, 1'b0, 5'd0,  32'h00000000, 4'd8},  // R8 beq not taken
    '{32'h12080002, 32'h00400040, 1'b0, 5'd0,  32'h00000000, 4'd8},  // R8 beq taken +2
    '{32'h1000FFFF, 32'h0040004C, 1'b0, 5'd0,  32'h00000000, 4'd8},  // R8 beq taken -1
    '{32'h08100040, 32'h0040004C, 1'b0, 5'd0,  32'h00000000, 4'd9},  // R9 j
    '{32'h0C100080, 32'h00400100, 1'b1, 5'd31, 32'h00400104, 4'd9},  // R9 jal link
    '{32'h03E00008, 32'h00400200, 1'b0, 5'd0,  32'h00000000, 4'd10}, // R10 jr r31
    '{32'hAFB3FFFC, 32'h00400104, 1'b0, 5'd0,  32'h00000000, 4'd7},  // R7 sw r19,-4(r29)
    '{32'h8FABFFFC, 32'h00400108, 1'b1, 5'd11, 32'h00000008, 4'd7},  // R7 lw negative offset
    '{32'h8FAC0004, 32'h0040010C, 1'b1, 5'd12, 32'h00000005, 4'd7},  // R7 neighbour intact
    '{32'h23BD0008, 32'h00400110, 1'b1, 5'd29, 32'h00000208, 4'd5},  // R5 addi r29,r29,8
    '{32'h8FADFFFC, 32'h00400114, 1'b1, 5'd13, 32'h00000005, 4'd7},  // R7 new base same word
    '{32'h8FAE03FC, 32'h00400118, 1'b1, 5'd14, 32'h00000005, 4'd7}   // R7 bits above 9 ignored
  };

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL R2 watchdog: actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    // reset state, R1
    repeat (3) @(negedge clk);
    #1;
    check("R1", "pc in reset", instr_addr, 32'h00400000);
    check("R1", "ready in reset", {31'b0, fetch_ready}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1", "ready before first edge", {31'b0, fetch_ready}, 32'd0);

    // table walk: R3..R11 plus R12 via debug port
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      instr_data  = VEC[i].ins;
      instr_valid = 1'b1;
      #1;
      check($sformatf("R%0d", VEC[i].rq), "pc", instr_addr, VEC[i].pc);
      check("R12", $sformatf("write enable vec %0d", i), {31'b0, dbg_wr_en}, {31'b0, VEC[i].we});
      if (VEC[i].we) begin
        check("R12", $sformatf("write index vec %0d", i), {27'b0, dbg_wr_idx}, {27'b0, VEC[i].wa});
        check($sformatf("R%0d", VEC[i].rq), $sformatf("write data vec %0d", i), dbg_wr_data, VEC[i].wd);
      end
    end

    // R2: stall with valid low
    @(negedge clk);
    instr_data  = 32'h200F0007;  // addi r15,r0,7
    instr_valid = 1'b0;
    #1;
    check("R2", "pc before stall", instr_addr, 32'h0040011C);
    check("R2", "no write while stalled", {31'b0, dbg_wr_en}, 32'd0);
    @(negedge clk);
    #1;
    check("R2", "pc held across edge", instr_addr, 32'h0040011C);
    instr_valid = 1'b1;
    #1;
    check("R5", "addi after stall", dbg_wr_data, 32'h00000007);
    @(negedge clk);
    instr_valid = 1'b0;
    #1;
    check("R2", "pc advanced once", instr_addr, 32'h00400120);

    // R1: reset in mid-run restores pc and stack pointer, clears others
    rst_n = 1'b0;
    #1;
    check("R1", "async pc reset", instr_addr, 32'h00400000);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    instr_data  = 32'h03A04820;  // add r9,r29,r0
    instr_valid = 1'b1;
    #1;
    check("R1", "ready after release", {31'b0, fetch_ready}, 32'd1);
    check("R1", "stack pointer restored", dbg_wr_data, 32'h00000200);
    @(negedge clk);
    instr_data = 32'h02004820;   // add r9,r16,r0
    #1;
    check("R1", "r16 cleared", dbg_wr_data, 32'h00000000);
    check("R1", "pc after one step", instr_addr, 32'h00400004);
    @(negedge clk);
    instr_valid = 1'b0;

    summary();
    $finish;
  end

endmodule